// File: doc/BRIEF.md
# Colour Button Code Lock

This block is a small controller that releases a door latch only after a fixed entry ritual. The user first presses a start button. Then the user presses single colour buttons in this order: red, blue, green, red. The lock opens for one clock cycle when the last correct press is taken. The controller then goes back to its idle state on its own.

A wrong colour returns the controller to idle and the door stays shut. Pressing two or more colour buttons in the same cycle also counts as a wrong entry, so holding every button down never works. Between presses the controller holds its position for as long as no colour button is down.

The button inputs are taken to be clean, synchronous and one cycle per press. The block derives "some colour is pressed" internally from the three colour lines.

Top module: `code_lock_top`

## Requirements
- R1: While `rst` is high at a rising edge, the controller enters the idle state and `unlock` reads 0 after that edge.
- R2: In the idle state the colour buttons have no effect; only `start_btn` high at an edge moves the controller to the armed state.
- R3: In the armed state and after each correct press, a cycle with no colour button down leaves the controller where it is, for any number of cycles.
- R4: The accepted code is red, then blue, then green, then red, each as a sole colour press. `unlock` is 1 in the cycle right after the edge that takes the final red, and in no other cycle.
- R5: A sole colour press other than the one expected at the current step sends the controller to idle. `unlock` stays 0 and the code must be restarted with `start_btn`.
- R6: Two or three colour buttons down in the same cycle count as a wrong entry at every step and send the controller to idle.
- R7: After one open cycle the controller returns to idle whatever the inputs are. Colour presses that follow without a new start do not open the lock.
- R8: `start_btn` has no effect in any state other than idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_btn | input | 1 | Start button, one-cycle press |
| red_btn | input | 1 | Red button |
| green_btn | input | 1 | Green button |
| blue_btn | input | 1 | Blue button |
| unlock | output | 1 | Registered door release, high for one cycle |

## Verification
The bench goes after the cases where a naive machine would let the door open.

- **Combined presses.** A combined press is tried at each step. A design that tests only the expected colour would advance on it and eventually open.
- **Wrong single colour.** A wrong colour followed by the rest of the code without a restart catches a machine that ignores wrong presses or only stalls on them.
- **Idle gaps and stray starts.** Idle gaps and stray start presses mid-sequence expose a machine that resets on silence or restarts on start.
- **After opening.** Colour presses right after an open cycle catch an open state that lingers or loops back into the code.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int NUM_COLORS = 3;
  localparam int COL_RED    = 0;
  localparam int COL_GREEN  = 1;
  localparam int COL_BLUE   = 2;
  localparam int STATE_W    = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_HIT1  = 3'd2,
    ST_HIT2  = 3'd3,
    ST_HIT3  = 3'd4,
    ST_OPEN  = 3'd5
  } lock_state_t;
endpackage

// File: rtl/press_decode.sv
module press_decode #(
  parameter int N = 3
) (
  input  logic [N-1:0] btn,
  output logic         any_press,
  output logic         multi_press,
  output logic [N-1:0] sole
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] pop;

  always_comb begin
    pop = '0;
    for (int i = 0; i < N; i++) pop = pop + CW'(btn[i]);
  end

  assign any_press   = (pop != '0);
  assign multi_press = (pop > CW'(1));

  for (genvar g = 0; g < N; g++) begin : g_sole
    assign sole[g] = btn[g] & ~multi_press;
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
#(
  parameter int N = NUM_COLORS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         any_press,
  input  logic         multi_press,
  input  logic [N-1:0] sole,
  output lock_state_t  state_o,
  output lock_state_t  next_o
);
  lock_state_t state, nxt;

  function automatic int want_color(lock_state_t s);
    case (s)
      ST_ARMED: return COL_RED;
      ST_HIT1:  return COL_BLUE;
      ST_HIT2:  return COL_GREEN;
      default:  return COL_RED;
    endcase
  endfunction

  function automatic lock_state_t advance(lock_state_t s);
    case (s)
      ST_ARMED: return ST_HIT1;
      ST_HIT1:  return ST_HIT2;
      ST_HIT2:  return ST_HIT3;
      ST_HIT3:  return ST_OPEN;
      default:  return ST_IDLE;
    endcase
  endfunction

  always_comb begin
    nxt = ST_IDLE;
    case (state)
      ST_IDLE: nxt = start ? ST_ARMED : ST_IDLE;
      ST_ARMED, ST_HIT1, ST_HIT2, ST_HIT3: begin
        if (!any_press)                    nxt = state;
        else if (sole[want_color(state)])  nxt = advance(state);
        else                               nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign state_o = state;
  assign next_o  = nxt;

  logic mid_seq;
  assign mid_seq = (state == ST_ARMED) || (state == ST_HIT1) ||
                   (state == ST_HIT2)  || (state == ST_HIT3);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE));
  assert_gap_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (mid_seq && !any_press) |=> $stable(state));
  assert_multi_aborts_R6: assert property (@(posedge clk) disable iff (rst)
    (mid_seq && multi_press) |=> (state == ST_IDLE));
  assert_open_leaves_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPEN) |=> (state == ST_IDLE));
endmodule

// File: rtl/out_reg.sv
module out_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/code_lock_top.sv
module code_lock_top
  import lock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_btn,
  input  logic red_btn,
  input  logic green_btn,
  input  logic blue_btn,
  output logic unlock
);
  logic [NUM_COLORS-1:0] btn_vec, sole;
  logic any_press, multi_press;
  lock_state_t state, nxt;
  logic open_next;

  always_comb begin
    btn_vec = '0;
    btn_vec[COL_RED]   = red_btn;
    btn_vec[COL_GREEN] = green_btn;
    btn_vec[COL_BLUE]  = blue_btn;
  end

  press_decode #(.N(NUM_COLORS)) u_dec (
    .btn(btn_vec), .any_press(any_press), .multi_press(multi_press), .sole(sole)
  );

  lock_fsm #(.N(NUM_COLORS)) u_fsm (
    .clk(clk), .rst(rst), .start(start_btn), .any_press(any_press),
    .multi_press(multi_press), .sole(sole), .state_o(state), .next_o(nxt)
  );

  assign open_next = (nxt == ST_OPEN);

  out_reg #(.W(1)) u_out (.clk(clk), .rst(rst), .d(open_next), .q(unlock));

  assert_unlock_in_open_R4: assert property (@(posedge clk) disable iff (rst)
    unlock |-> (state == ST_OPEN));
  assert_unlock_single_R4: assert property (@(posedge clk) disable iff (rst)
    unlock |=> !unlock);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HIT1 && start_btn && !any_press) |=> (state == ST_HIT1));
endmodule

// File: tb/sim_code_lock_top.sv
module sim_code_lock_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s = 0, r = 0, g = 0, b = 0;
  logic unlock;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  code_lock_top u0 (
    .clk(clk), .rst(rst), .start_btn(s), .red_btn(r),
    .green_btn(g), .blue_btn(b), .unlock(unlock)
  );

  // Monitor: each negedge, compare the result of the edge just taken
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (unlock !== e) begin
        errors++;
        $display("FAIL %s: unlock=%0b expected %0b", t, unlock, e);
      end
    end
  end

  // Driver: apply one cycle of buttons and queue the expected unlock level
  task automatic step(input bit ss, input bit rr, input bit gg, input bit bb,
                      input bit exp, input string tag);
    @(negedge clk);
    #1;
    s = ss; r = rr; g = gg; b = bb;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic start_p(input string t);          step(1,0,0,0,0,t); endtask
  task automatic red_p(input bit e, input string t); step(0,1,0,0,e,t); endtask
  task automatic blu_p(input string t);            step(0,0,0,1,0,t); endtask
  task automatic grn_p(input string t);            step(0,0,1,0,0,t); endtask
  task automatic none_p(input string t);           step(0,0,0,0,0,t); endtask
  task automatic all_p(input string t);            step(0,1,1,1,0,t); endtask

  task automatic good_code(input string t);
    start_p(t); red_p(0,t); blu_p(t); grn_p(t); red_p(1,t); none_p(t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (unlock !== 1'b0) begin
      errors++;
      $display("FAIL R1: unlock=%0b expected 0 in reset", unlock);
    end
    @(negedge clk); #1; rst = 0;

    // R1/R4: clean code from reset opens once
    good_code("R1");
    good_code("R4");

    // R7: colour presses after opening do nothing without start
    good_code("R7");
    red_p(0,"R7"); blu_p("R7"); grn_p("R7"); red_p(0,"R7"); none_p("R7");

    // R2: colours in idle ignored, then code without start fails
    step(0,1,1,1,0,"R2"); red_p(0,"R2"); blu_p("R2"); grn_p("R2"); red_p(0,"R2");
    good_code("R2");

    // R3: gaps between presses hold position
    start_p("R3"); none_p("R3"); none_p("R3"); none_p("R3");
    red_p(0,"R3"); none_p("R3"); blu_p("R3"); none_p("R3"); none_p("R3");
    grn_p("R3"); none_p("R3"); red_p(1,"R3"); none_p("R3");

    // R8: start presses mid-sequence are ignored
    start_p("R8"); start_p("R8"); red_p(0,"R8"); start_p("R8");
    blu_p("R8"); start_p("R8"); grn_p("R8"); start_p("R8"); red_p(1,"R8"); none_p("R8");

    // R5: wrong colour at each step aborts
    start_p("R5"); grn_p("R5"); blu_p("R5"); grn_p("R5"); red_p(0,"R5");
    start_p("R5"); red_p(0,"R5"); red_p(0,"R5"); grn_p("R5"); red_p(0,"R5");
    start_p("R5"); red_p(0,"R5"); blu_p("R5"); red_p(0,"R5"); red_p(0,"R5");
    start_p("R5"); red_p(0,"R5"); blu_p("R5"); grn_p("R5"); blu_p("R5"); red_p(0,"R5");
    good_code("R5");

    // R6: all buttons together at every step never opens
    start_p("R6"); all_p("R6"); all_p("R6"); all_p("R6"); all_p("R6"); none_p("R6");
    for (int k = 0; k < 4; k++) begin
      start_p("R6");
      if (k > 0) red_p(0,"R6");
      if (k > 1) blu_p("R6");
      if (k > 2) grn_p("R6");
      all_p("R6");
      if (k < 1) red_p(0,"R6");
      if (k < 2) blu_p("R6");
      if (k < 3) grn_p("R6");
      red_p(0,"R6");
      none_p("R6");
    end
    // R6: two-button combination that includes the expected colour
    start_p("R6"); step(0,1,0,1,0,"R6"); blu_p("R6"); grn_p("R6"); red_p(0,"R6");
    start_p("R6"); red_p(0,"R6"); step(0,0,1,1,0,"R6"); grn_p("R6"); red_p(0,"R6");
    good_code("R6");

    none_p("R7");
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
      wait (done);
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule